// File: doc/BRIEF.md
# Fully associative translation buffer with fill-slot selection

This block stores a set of translation entries, each a pair of words: a tag and an entry word. The entry word holds a valid flag and a lock flag at fixed bit positions. A small bank of internal registers sits beside the buffer. One of them, the pending-tag register, holds the tag that the next write into the buffer will use. Software loads this register first, then writes the entry word.

Requests arrive on a single command port, at most one per cycle, and every request gets exactly one registered response in the following cycle. There are five commands. Register write and register read reach the register bank. Automatic insert picks a slot by itself. Indexed write names its slot in the address. Tag probe searches every slot in parallel for a valid entry with an equal tag. The slot chooser for the automatic insert first takes the lowest free slot. When no slot is free, it falls back to the lowest slot that is not locked. When every slot is both valid and locked, the insert is discarded and a sticky overflow flag is raised.

Top module: `tlb_fill_buf`

## Requirements
- R1: After reset, every slot is invalid, so any probe misses. Every internal register reads zero, `overflow` is 0 and `rsp_valid` is 0.
- R2: Each accepted request (`req_valid`=1) produces `rsp_valid`=1 in the next cycle. A cycle without a request produces `rsp_valid`=0 in the next cycle.
- R3: Command codes are: 0 register write, 1 register read, 2 automatic insert, 3 indexed write, 4 tag probe. Register commands select the register with `req_addr[6:3]`. A read returns the value last written to that register, and a write leaves every other register unchanged.
- R4: An automatic insert stores register 6 as the tag and `req_wdata` as the entry word. Its response carries the chosen slot number in the low bits of `rsp_data`, with `rsp_miss`=0.
- R5: An automatic insert fills the lowest-numbered slot whose entry word has bit 63 (valid) clear.
- R6: When no slot is invalid, an automatic insert replaces the lowest-numbered slot whose entry word has bit 6 (lock) clear.
- R7: When every slot is valid and locked, an automatic insert changes no slot. It responds with `rsp_miss`=1 and sets `overflow`, which stays 1 until reset.
- R8: An indexed write stores register 6 as the tag and `req_wdata` as the entry word into the slot given by `req_addr[3+log2(ENTRIES)-1:3]`. Address bits above that field are ignored. The response reports the slot.
- R9: A probe with value `req_wdata` that equals the tag of a valid slot returns that tag with `rsp_miss`=0.
- R10: A probe that matches no valid slot returns zero with `rsp_miss`=1. A slot whose valid bit is clear never matches, even if its tag is equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Command code |
| req_addr | input | AW | Register or slot address (byte address, bits [2:0] unused) |
| req_wdata | input | DW | Write data, or the probe value |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DW | Read data, probe tag, or slot number |
| rsp_miss | output | 1 | Probe missed or insert dropped |
| overflow | output | 1 | Sticky: an insert found no replaceable slot |

## Verification
The bench builds the block with ENTRIES=8 and all other parameters at their defaults. With eight slots, a handful of requests fills the buffer completely. This makes the fall-back to the lowest unlocked slot and the fully locked drop, with its sticky overflow, directly reachable. An indexed-write address of 9 with eight slots shows that address bits above the slot field are ignored.

// File: rtl/tlb_fill_buf.sv
module tlb_fill_buf #(
  parameter int ENTRIES   = 64,
  parameter int DW        = 64,
  parameter int AW        = 12,
  parameter int REGS      = 16,
  parameter int TAG_REG   = 6,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_miss,
  output logic          overflow
);
  localparam int IW = $clog2(ENTRIES);
  localparam int RW = $clog2(REGS);
  localparam logic [2:0] OP_RWR = 3'd0, OP_RRD = 3'd1, OP_INS = 3'd2,
                         OP_IDX = 3'd3, OP_PRB = 3'd4;

  logic [DW-1:0] tag_q [ENTRIES];
  logic [DW-1:0] ent_q [ENTRIES];
  logic [DW-1:0] reg_q [REGS];

  wire [IW-1:0] addr_slot = req_addr[3 +: IW];
  wire [RW-1:0] addr_reg  = req_addr[3 +: RW];

  logic [IW-1:0] free_idx, unl_idx, hit_idx;
  logic          free_any, unl_any, hit_any;

  always_comb begin
    free_idx = '0; free_any = 1'b0;
    unl_idx  = '0; unl_any  = 1'b0;
    hit_idx  = '0; hit_any  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_q[i][VALID_BIT]) begin
        free_idx = IW'(i); free_any = 1'b1;
      end
      if (!ent_q[i][LOCK_BIT]) begin
        unl_idx = IW'(i); unl_any = 1'b1;
      end
      if (ent_q[i][VALID_BIT] && tag_q[i] == req_wdata) begin
        hit_idx = IW'(i); hit_any = 1'b1;
      end
    end
  end

  wire           ins_go  = req_valid && req_op == OP_INS;
  wire           idx_go  = req_valid && req_op == OP_IDX;
  wire           ins_ok  = free_any || unl_any;
  wire [IW-1:0]  ins_idx = free_any ? free_idx : unl_idx;
  wire           wr_en   = idx_go || (ins_go && ins_ok);
  wire [IW-1:0]  wr_idx  = idx_go ? addr_slot : ins_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ent_q[i] <= '0;
      end
      for (int r = 0; r < REGS; r++) reg_q[r] <= '0;
      overflow  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_data  <= '0;
      rsp_miss  <= 1'b0;
      if (wr_en) begin
        tag_q[wr_idx] <= reg_q[TAG_REG];
        ent_q[wr_idx] <= req_wdata;
      end
      if (req_valid) begin
        case (req_op)
          OP_RWR: reg_q[addr_reg] <= req_wdata;
          OP_RRD: rsp_data <= reg_q[addr_reg];
          OP_INS: begin
            rsp_data <= DW'(ins_idx);
            rsp_miss <= !ins_ok;
            if (!ins_ok) overflow <= 1'b1;
          end
          OP_IDX: rsp_data <= DW'(addr_slot);
          OP_PRB: begin
            rsp_data <= hit_any ? tag_q[hit_idx] : '0;
            rsp_miss <= !hit_any;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlb_fill_buf_chk.sv
module tlb_fill_buf_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_op,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_miss,
  input logic          overflow
);
  // R2
  rsp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R9
  probe_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |=> (rsp_miss || rsp_data == $past(req_wdata)));
  // R10
  probe_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |=> (!rsp_miss || rsp_data == '0));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(overflow));
  // R7
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (rsp_valid && rsp_miss));
endmodule

bind tlb_fill_buf tlb_fill_buf_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_tlb_fill_buf.sv
module sim_tlb_fill_buf;
  localparam int N  = 8;
  localparam int DW = 64;
  localparam int AW = 12;
  localparam logic [DW-1:0] V = 64'h8000_0000_0000_0000;
  localparam logic [DW-1:0] L = 64'h40;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_miss, overflow;
  logic [DW-1:0] rsp_data;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlb_fill_buf #(.ENTRIES(N), .DW(DW), .AW(AW)) u0 (.*);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", {63'd0, rsp_valid}, 64'd1);
  endtask

  task automatic set_tag(logic [DW-1:0] t);
    xfer(3'd0, AW'(6 << 3), t);
  endtask

  task automatic probe(string req, logic [DW-1:0] t, bit hit);
    xfer(3'd4, '0, t);
    chk(req, {63'd0, rsp_miss}, {63'd0, !hit});
    chk(req, rsp_data, hit ? t : '0);
  endtask

  task automatic insert(string req, logic [DW-1:0] t, logic [DW-1:0] e, int slot);
    set_tag(t);
    xfer(3'd2, '0, e);
    chk(req, {63'd0, rsp_miss}, 64'd0);
    chk(req, rsp_data, DW'(slot));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", {63'd0, rsp_valid}, 64'd0);
    chk("R1", {63'd0, overflow}, 64'd0);
    probe("R1", 64'd0, 1'b0);
    xfer(3'd1, AW'(6 << 3), '0);
    chk("R1", rsp_data, 64'd0);
  endtask

  task automatic t_regs();
    set_tag(64'hA5A5_0000_1234_5678);
    xfer(3'd0, AW'(3 << 3), 64'h0BAD);
    xfer(3'd1, AW'(6 << 3), '0);
    chk("R3", rsp_data, 64'hA5A5_0000_1234_5678);
    xfer(3'd1, AW'(3 << 3), '0);
    chk("R3", rsp_data, 64'h0BAD);
    @(negedge clk);
    chk("R2", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_fill();
    insert("R4", 64'h100, V | L, 0);
    insert("R5", 64'h101, V | L, 1);
    insert("R5", 64'h102, V, 2);
    insert("R5", 64'h103, V, 3);
    probe("R9", 64'h101, 1'b1);
    set_tag(64'h102);
    xfer(3'd3, AW'(2 << 3), 64'd0);
    chk("R8", rsp_data, 64'd2);
    probe("R10", 64'h102, 1'b0);
    insert("R5", 64'h202, V, 2);
    probe("R9", 64'h202, 1'b1);
    for (int i = 4; i < N; i++) insert("R5", 64'h100 + DW'(i), V, i);
  endtask

  task automatic t_replace();
    insert("R6", 64'h300, V, 2);
    probe("R6", 64'h202, 1'b0);
    probe("R6", 64'h300, 1'b1);
    probe("R6", 64'h100, 1'b1);
    chk("R6", {63'd0, overflow}, 64'd0);
  endtask

  task automatic t_index_wrap();
    set_tag(64'h900);
    xfer(3'd3, AW'(9 << 3), V | L);
    chk("R8", rsp_data, 64'd1);
    probe("R8", 64'h101, 1'b0);
    probe("R8", 64'h900, 1'b1);
  endtask

  task automatic t_locked_full();
    for (int i = 0; i < N; i++) begin
      set_tag(64'h500 + DW'(i));
      xfer(3'd3, AW'(i << 3), V | L);
    end
    set_tag(64'h777);
    xfer(3'd2, '0, V);
    chk("R7", {63'd0, rsp_miss}, 64'd1);
    chk("R7", {63'd0, overflow}, 64'd1);
    probe("R7", 64'h777, 1'b0);
    for (int i = 0; i < N; i++) probe("R7", 64'h500 + DW'(i), 1'b1);
    xfer(3'd1, AW'(6 << 3), '0);
    chk("R7", {63'd0, overflow}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_fill();
    t_replace();
    t_index_wrap();
    t_locked_full();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule